// File: doc/BRIEF.md
# Power-of-two prescaled PWM generator

This block produces one pulse-width-modulated output from a single clock. The input clock is first divided by a power of two, selectable from 1 up to 2^24. Each divided tick advances a 10-bit period counter. The output is high at the start of every period for a programmed number of ticks and low for the remainder. Software controls the block through two 32-bit word registers, accessed with a simple valid/write strobe: a control word and a count word.

A staging bit in the control word lets software change the period, the high phase and the divide exponent as one set. While the bit is set, new values are held back and only their read-back changes. Clearing the bit commits all of them together. If the channel is running, the commit waits for the end of the current period so that no partial period is produced. If the channel is stopped, the commit happens at once. A period or phase of zero is treated as an illegal setting: the channel stays idle with its output low.

Top module: `pwm_p2_timer`

## Requirements
- R1: After reset both registers read as zero and `pwm_out` is low.
- R2: The control word is at byte offset 0x0, with enable at bit 0, a spare read/write bit at bit 4, stage at bit 11, divide exponent bit 0 at bit 15 and divide exponent bits 4:1 at bits 19:16. The count word is at byte offset 0x4, with the period at bits 25:16 and the high phase at bits 9:0. All other bits read as zero, and any other offset reads as zero.
- R3: While running with period P and phase H < P, the output is high for H ticks and then low for P-H ticks, repeating.
- R4: One tick lasts 2^d clock cycles, where d = 2*ctrl[19:16] + ctrl[15] (limited to 24).
- R5: When H >= P (both nonzero), the output stays high continuously.
- R6: With the active period or phase equal to 0, the output stays low even when enable is set.
- R7: Clearing enable drives the output low on the next cycle. Setting enable again restarts the period from its beginning, with the output high.
- R8: While stage is 1, writes to the count word and the exponent fields appear on read-back but do not change the running waveform.
- R9: Clearing stage while running applies the staged period, phase and exponent together at the next period boundary.
- R10: Clearing stage (or writing with stage 0) while stopped applies the settings immediately, so the first period after enabling uses them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| pwm_out | output | 1 | PWM waveform |

## Verification
The checker watches four things on every cycle. The output must be low whenever the channel is disabled or holds a zero setting. The tick counter must stay below the active period. The counter may only move on a prescaler tick. The active settings must stay frozen while stage is set, and while running they may change only at a period boundary. The remaining behaviour can only be shown by the bench's scenarios: the exact high and low lengths for a given period, phase and exponent, the register read-back layout, and the moment a staged commit takes effect. The bench measures these against lengths derived from the requirements.

// File: rtl/pwm_p2_pkg.sv
// Package: shared widths and the active-configuration type of the PWM timer.
// Assumes a 32-bit register word and a 10-bit counter.
package pwm_p2_pkg;
    localparam int unsigned CNT_W  = 10;
    localparam int unsigned EXP_W  = 5;
    localparam int unsigned WORD_W = 32;

    // Bit positions of the control word
    localparam int unsigned C_EN    = 0;
    localparam int unsigned C_SPARE = 4;
    localparam int unsigned C_STAGE = 11;
    localparam int unsigned C_ELSB  = 15;
    localparam int unsigned C_EHI   = 16;
    // Bit position of the period in the count word
    localparam int unsigned N_PER   = 16;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] phase;
        logic [EXP_W-1:0] dexp;
    } pwm_cfg_t;
endpackage

// File: rtl/pwm_p2_regs.sv
// Register file: holds the programmed control and count words.
// It also presents their next-cycle values so that the commit logic can load
// a new setting in the same cycle it is written. Assumes word-aligned accesses.
module pwm_p2_regs
    import pwm_p2_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              en_q,
    output logic              sync_q,
    output logic              sync_nx,
    output pwm_cfg_t          prog_nx
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             wr_ctrl, wr_cnt;
    logic             spare_q, elsb_q;
    logic [3:0]       ehi_q;
    logic [CNT_W-1:0] per_q, ph_q;
    logic             en_nx, spare_nx, elsb_nx;
    logic [3:0]       ehi_nx;
    logic [CNT_W-1:0] per_nx, ph_nx;

    assign idx     = reg_addr[ADDR_W-1:2];
    assign wr_ctrl = reg_valid && reg_write && (idx == IDX_W'(0));
    assign wr_cnt  = reg_valid && reg_write && (idx == IDX_W'(1));

    // Next values of every programmed field
    always_comb begin
        en_nx    = wr_ctrl ? reg_wdata[C_EN]          : en_q;
        spare_nx = wr_ctrl ? reg_wdata[C_SPARE]       : spare_q;
        sync_nx  = wr_ctrl ? reg_wdata[C_STAGE]       : sync_q;
        elsb_nx  = wr_ctrl ? reg_wdata[C_ELSB]        : elsb_q;
        ehi_nx   = wr_ctrl ? reg_wdata[C_EHI +: 4]    : ehi_q;
        per_nx   = wr_cnt  ? reg_wdata[N_PER +: CNT_W] : per_q;
        ph_nx    = wr_cnt  ? reg_wdata[0 +: CNT_W]     : ph_q;
    end

    assign prog_nx = '{period: per_nx, phase: ph_nx, dexp: {ehi_nx, elsb_nx}};

    // Programmed register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0; spare_q <= 1'b0; sync_q <= 1'b0;
            elsb_q <= 1'b0; ehi_q <= '0; per_q <= '0; ph_q <= '0;
        end else begin
            en_q <= en_nx; spare_q <= spare_nx; sync_q <= sync_nx;
            elsb_q <= elsb_nx; ehi_q <= ehi_nx; per_q <= per_nx; ph_q <= ph_nx;
        end
    end

    // Read multiplexer; unused bits and offsets return zero
    always_comb begin
        reg_rdata = '0;
        if (idx == IDX_W'(0)) begin
            reg_rdata[C_EN]       = en_q;
            reg_rdata[C_SPARE]    = spare_q;
            reg_rdata[C_STAGE]    = sync_q;
            reg_rdata[C_ELSB]     = elsb_q;
            reg_rdata[C_EHI +: 4] = ehi_q;
        end else if (idx == IDX_W'(1)) begin
            reg_rdata[N_PER +: CNT_W] = per_q;
            reg_rdata[0 +: CNT_W]     = ph_q;
        end
    end
endmodule

// File: rtl/pwm_p2_prescaler.sv
// Prescaler: emits a one-cycle tick every 2^d clock cycles while running.
// The exponent is limited to MAX_EXP. It restarts from zero whenever run is low.
module pwm_p2_prescaler
    import pwm_p2_pkg::*;
#(
    parameter int unsigned MAX_EXP = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EXP_W-1:0] dexp,
    output logic             tick
);
    logic [EXP_W-1:0]   d_eff;
    logic [MAX_EXP-1:0] mask, pre_q;

    // Clamp the exponent and build the low-bit mask
    always_comb begin
        d_eff = (dexp > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : dexp;
        for (int i = 0; i < int'(MAX_EXP); i++)
            mask[i] = (i < int'(d_eff));
    end

    assign tick = run && ((pre_q & mask) == mask);

    // Cycle counter within one tick
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) pre_q <= '0;
        else                        pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/pwm_p2_counter.sv
// Period counter and phase comparator: counts ticks from 0 to period-1 and
// drives the output high while the count is below the phase.
// Assumes the period does not change mid-period while running.
module pwm_p2_counter
    import pwm_p2_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] phase,
    output logic [CNT_W-1:0] cnt_q,
    output logic             boundary,
    output logic             wave
);
    assign boundary = tick && (cnt_q == period - CNT_W'(1));
    assign wave     = run && (cnt_q < phase);

    // Tick counter, wrapping at the period
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (boundary)  cnt_q <= '0;
        else if (tick)      cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pwm_p2_timer.sv
// Top: single-channel PWM timer with a power-of-two prescaler and staged,
// all-at-once settings commit. Assumes word-aligned 32-bit register accesses.
module pwm_p2_timer
    import pwm_p2_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned MAX_EXP = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              pwm_out
);
    logic             en_q, sync_q, sync_nx, run, tick, boundary;
    pwm_cfg_t         prog_nx, cfg_a;
    logic [CNT_W-1:0] cnt_q, per_a, ph_a;
    logic [EXP_W-1:0] d_a;

    pwm_p2_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .en_q(en_q), .sync_q(sync_q), .sync_nx(sync_nx), .prog_nx(prog_nx)
    );

    assign per_a = cfg_a.period;
    assign ph_a  = cfg_a.phase;
    assign d_a   = cfg_a.dexp;
    assign run   = en_q && (per_a != '0) && (ph_a != '0);

    // Active settings: loaded when not staged and stopped or at a boundary
    always_ff @(posedge clk) begin
        if (!rst_n)                             cfg_a <= '0;
        else if (!sync_nx && (!run || boundary)) cfg_a <= prog_nx;
    end

    pwm_p2_prescaler #(.MAX_EXP(MAX_EXP)) pre_i (
        .clk(clk), .rst_n(rst_n), .run(run), .dexp(d_a), .tick(tick)
    );

    pwm_p2_counter cnt_i (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .period(per_a),
        .phase(ph_a), .cnt_q(cnt_q), .boundary(boundary), .wave(pwm_out)
    );
endmodule

// File: rtl/pwm_p2_timer_chk.sv
// Checker: cycle properties of the PWM timer, bound to its top module.
module pwm_p2_timer_chk
    import pwm_p2_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_out,
    input logic             en_q,
    input logic             sync_q,
    input logic             run,
    input logic             tick,
    input logic             boundary,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] per_a,
    input logic [CNT_W-1:0] ph_a,
    input logic [EXP_W-1:0] d_a
);
    // R6 R7
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q || per_a == '0 || ph_a == '0) |-> !pwm_out);
    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_a != '0) |-> (cnt_q < per_a));
    // R4
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(tick)) |-> $stable(cnt_q));
    // R8
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q |-> ($stable(per_a) && $stable(ph_a) && $stable(d_a)));
    // R9
    edge_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(boundary)) |->
            ($stable(per_a) && $stable(ph_a) && $stable(d_a)));
endmodule

bind pwm_p2_timer pwm_p2_timer_chk chk_i (
    .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .en_q(en_q), .sync_q(sync_q),
    .run(run), .tick(tick), .boundary(boundary), .cnt_q(cnt_q),
    .per_a(per_a), .ph_a(ph_a), .d_a(d_a)
);

// File: tb/pwm_p2_timer_tb_top.sv
// Bench: directed corner cases plus seeded random configurations, each
// checked against lengths computed from the requirements.
module pwm_p2_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out;
    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwm_p2_timer dut_i (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pwm_out(pwm_out)
    );

    function automatic logic [31:0] ctrl_w(bit en, bit spare, bit stg, int d);
        logic [31:0] w = '0;
        w[0] = en; w[4] = spare; w[11] = stg; w[15] = d[0]; w[19:16] = 4'(d >> 1);
        return w;
    endfunction

    function automatic logic [31:0] cnt_w(int per, int ph);
        logic [31:0] w = '0;
        w[25:16] = 10'(per); w[9:0] = 10'(ph);
        return w;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; #1 d = reg_rdata;
    endtask

    // Measure one high/low pair starting from a rising edge of the output
    task automatic measure(output int hi, output int lo);
        logic prev;
        int   guard = 0;
        hi = 0; lo = 0;
        @(negedge clk); prev = pwm_out;
        while (!(prev == 1'b0 && pwm_out == 1'b1) && guard < 6000) begin
            prev = pwm_out; @(negedge clk); guard++;
        end
        if (guard >= 6000) begin hi = -1; lo = -1; return; end
        while (pwm_out == 1'b1 && hi < 6000) begin hi++; @(negedge clk); end
        while (pwm_out == 1'b0 && lo < 6000) begin lo++; @(negedge clk); end
    endtask

    task automatic count_high(int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin @(negedge clk); if (pwm_out) h++; end
    endtask

    // Program a stopped channel and start it
    task automatic start(int per, int ph, int d);
        wr(4'h0, ctrl_w(0, 0, 0, d));
        wr(4'h4, cnt_w(per, ph));
        wr(4'h0, ctrl_w(1, 0, 0, d));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int hi, lo, h;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, r); chk("R1", "ctrl after reset", r, 0);
        rd(4'h4, r); chk("R1", "count after reset", r, 0);
        chk("R1", "pwm after reset", pwm_out, 0);

        // R2 register layout
        wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, r); chk("R2", "ctrl mask", r, 32'h000F_8811);
        wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, r); chk("R2", "count mask", r, 32'h03FF_03FF);
        rd(4'h8, r); chk("R2", "unused offset", r, 0);
        wr(4'h0, 32'h0000_0010); rd(4'h0, r); chk("R2", "spare bit", r, 32'h10);

        // R6 zero phase / zero period keep the output low
        start(5, 0, 0); count_high(60, h); chk("R6", "phase 0 high cycles", h, 0);
        start(0, 3, 0); count_high(60, h); chk("R6", "period 0 high cycles", h, 0);

        // R3 basic waveform, R4 prescaled waveform
        start(4, 1, 0); measure(hi, lo);
        chk("R3", "p4 h1 high", hi, 1); chk("R3", "p4 h1 low", lo, 3);
        start(3, 2, 2); measure(hi, lo);
        chk("R4", "d2 high", hi, 8); chk("R4", "d2 low", lo, 4);
        start(2, 1, 3); measure(hi, lo);
        chk("R4", "d3 high", hi, 8); chk("R4", "d3 low", lo, 8);

        // R5 phase at or above period
        start(4, 4, 1); count_high(40, h); chk("R5", "ph=per high cycles", h, 40);
        start(3, 9, 0); count_high(40, h); chk("R5", "ph>per high cycles", h, 40);

        // R7 disable and restart
        start(10, 5, 0); repeat (7) @(negedge clk);
        wr(4'h0, ctrl_w(0, 0, 0, 0));
        chk("R7", "low after disable", pwm_out, 0);
        count_high(30, h); chk("R7", "stays low", h, 0);
        @(negedge clk); reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 4'h0;
        reg_wdata = ctrl_w(1, 0, 0, 0);
        @(negedge clk); reg_valid = 1'b0; reg_write = 1'b0;
        chk("R7", "high on restart", pwm_out, 1);

        // R8 / R9 staged update while running
        start(6, 2, 1);
        wr(4'h0, ctrl_w(1, 0, 1, 1));
        wr(4'h4, cnt_w(3, 1));
        wr(4'h0, ctrl_w(1, 0, 1, 0));
        rd(4'h4, r); chk("R8", "staged count readback", r, cnt_w(3, 1));
        rd(4'h0, r); chk("R8", "staged ctrl readback", r, ctrl_w(1, 0, 1, 0));
        measure(hi, lo); chk("R8", "old high kept", hi, 4); chk("R8", "old low kept", lo, 8);
        wr(4'h0, ctrl_w(1, 0, 0, 0));
        measure(hi, lo); measure(hi, lo);
        chk("R9", "committed high", hi, 1); chk("R9", "committed low", lo, 2);

        // R10 commit while stopped applies at once
        wr(4'h0, ctrl_w(0, 0, 1, 0));
        wr(4'h4, cnt_w(2, 1));
        wr(4'h0, ctrl_w(0, 0, 0, 0));
        @(negedge clk); reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 4'h0;
        reg_wdata = ctrl_w(1, 0, 0, 0);
        @(negedge clk); reg_valid = 1'b0; reg_write = 1'b0;
        chk("R10", "first cycle", pwm_out, 1);
        @(negedge clk); chk("R10", "second cycle", pwm_out, 0);
        @(negedge clk); chk("R10", "third cycle", pwm_out, 1);

        // R3 R4 R5 random configurations
        for (int it = 0; it < 20; it++) begin
            int per = 1 + int'($urandom % 16);
            int ph  = 1 + int'($urandom % 16);
            int d   = int'($urandom % 4);
            start(per, ph, d);
            if (ph >= per) begin
                count_high(3 * per * (1 << d), h);
                chk("R5", "random constant high", h, 3 * per * (1 << d));
            end else begin
                measure(hi, lo);
                chk("R3", "random high", hi, ph * (1 << d));
                chk("R4", "random low", lo, (per - ph) * (1 << d));
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule